// File: doc/BRIEF.md
# Deferred-Commit Direct-Mapped Data Cache

This block is a small direct-mapped data cache whose store path never stalls the pipeline. In the memory-stage cycle of a store, the cache only checks the tag of the new store. In that same cycle it writes the store captured on the previous store into the data array. The latest store that hits sits in a one-entry pending register, made of a word address, a data word, byte enables and a valid bit. Loads that address the same word see the pending bytes merged over the array word.

The array holds 1 KB in 32 lines of 32 bytes. An address splits into tag (bits 31:10), line index (bits 9:5), word select (bits 4:2) and byte lane (bits 1:0). Refill is not part of the block. An external controller watches the one-cycle miss flag and writes lines word by word through the fill port. Stores follow a no-write-allocate policy. Every request gets a registered response one cycle later.

Top module: `dsb_cache`

## Requirements
- R1: After reset, every line and the pending store entry are invalid, no response is flagged, and the first load to any address misses.
- R2: Address fields: tag = addr[31:10], index = addr[9:5], word = addr[4:2]; addr[1:0] is ignored. Byte lane b of a word is bits 8b+7:8b and is governed by be[b].
- R3: A request accepted in cycle N raises rsp_valid in cycle N+1 and only then. A load that hits returns the stored word on rsp_rdata with rsp_hit=1 and rsp_miss=0.
- R4: A request whose line is invalid or whose tag differs raises rsp_miss (and not rsp_hit) for exactly its one response cycle.
- R5: A store that hits does not write the array in its own cycle. It is captured as the valid pending entry.
- R6: In every store cycle, whether that store hits or misses, a valid pending entry is written into the array, limited to its enabled bytes, and then leaves the pending register.
- R7: A store that misses raises rsp_miss, leaves the array unchanged and leaves the pending register empty.
- R8: A load to the word address held by a valid pending entry returns the enabled pending bytes merged over the array word. Loads to other words return the array word alone, and loads do not change the pending entry.
- R9: A fill writes one word, sets the line's tag and valid bit, and drops a pending entry at that index whose tag differs. A pending entry with the same tag is kept. Fill and request are never presented in the same cycle.
- R10: Bytes whose enable is 0 keep their previous value, including across back-to-back stores to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Pipeline request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store data word |
| req_be | input | 4 | Store byte enables |
| fill_en | input | 1 | Controller writes one word into the array |
| fill_addr | input | 32 | Address of the filled word (tag, index, word) |
| fill_data | input | 32 | Filled data word |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Previous request hit |
| rsp_miss | output | 1 | One-cycle miss flag to the refill controller |
| rsp_rdata | output | 32 | Load data (merged with pending store) |

## Verification
Directed sequences cover several cases. Isolated loads separate array reads from forwarding. Pairs of stores to different words in one line show that the first store is committed only when the second arrives. Two stores to the same word check the byte merge. A store miss at an occupied index shows that the miss leaves the resident line alone while still committing the older entry. A fill with a different tag between two stores, followed by a refill with the old tag, shows which store reached the array and which was dropped. A same-tag fill shows that the pending entry survives. A random mix over two indices and two tags then exercises hits, conflicts and forwarding together against a reference model.

// File: rtl/dsb_cache_pkg.sv
package dsb_cache_pkg;
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_e;
endpackage

// File: rtl/dsb_tag_store.sv
module dsb_tag_store #(
  parameter int LINES = 32,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/dsb_data_store.sv
module dsb_data_store #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int ENT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ENT_W-1:0]  rd_ent,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cm_en,
  input  logic [ENT_W-1:0]  cm_ent,
  input  logic [DATA_W-1:0] cm_data,
  input  logic [BE_W-1:0]   cm_be,
  input  logic              fl_en,
  input  logic [ENT_W-1:0]  fl_ent,
  input  logic [DATA_W-1:0] fl_data
);
  logic [7:0] mem_q [DEPTH][BE_W];
  logic [BE_W-1:0] lane_we [DEPTH];
  logic [7:0]      lane_wd [DEPTH][BE_W];

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      for (int b = 0; b < BE_W; b++) begin
        if (fl_en && (fl_ent == ENT_W'(e))) begin
          lane_we[e][b] = 1'b1;
          lane_wd[e][b] = fl_data[8*b +: 8];
        end else begin
          lane_we[e][b] = cm_en && (cm_ent == ENT_W'(e)) && cm_be[b];
          lane_wd[e][b] = cm_data[8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++)
      for (int b = 0; b < BE_W; b++)
        if (lane_we[e][b]) mem_q[e][b] <= lane_wd[e][b];
  end

  always_comb begin
    for (int b = 0; b < BE_W; b++) rd_data[8*b +: 8] = mem_q[rd_ent][b];
  end
endmodule

// File: rtl/dsb_store_buf.sv
module dsb_store_buf #(
  parameter int WA_W   = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en,
  input  logic              st_hit,
  input  logic [WA_W-1:0]   st_waddr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  input  logic              drop_en,
  input  logic [WA_W-1:0]   ld_waddr,
  input  logic [DATA_W-1:0] arr_word,
  output logic [DATA_W-1:0] fwd_word,
  output logic              sb_vld,
  output logic [WA_W-1:0]   sb_waddr,
  output logic [DATA_W-1:0] sb_data,
  output logic [BE_W-1:0]   sb_be
);
  logic vld_d, cap_en;

  always_comb begin
    vld_d  = sb_vld;
    cap_en = st_en && st_hit;
    if (st_en)        vld_d = st_hit;
    else if (drop_en) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sb_vld <= 1'b0;
    else        sb_vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      sb_waddr <= st_waddr;
      sb_data  <= st_data;
      sb_be    <= st_be;
    end
  end

  logic word_match;
  assign word_match = sb_vld && (sb_waddr == ld_waddr);

  always_comb begin
    for (int b = 0; b < BE_W; b++)
      fwd_word[8*b +: 8] = (word_match && sb_be[b]) ? sb_data[8*b +: 8]
                                                    : arr_word[8*b +: 8];
  end
endmodule

// File: rtl/dsb_cache.sv
module dsb_cache
  import dsb_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 32,
  localparam int BE_W   = DATA_W / 8,
  localparam int BSEL_W = $clog2(BE_W),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int WSEL_W = OFF_W - BSEL_W,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int WA_W   = ADDR_W - BSEL_W,
  localparam int DEPTH  = NUM_LINES * (LINE_BYTES / BE_W),
  localparam int ENT_W  = IDX_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [DATA_W-1:0] rsp_rdata
);
  acc_e acc;
  assign acc = req_store ? ACC_STORE : ACC_LOAD;

  // address fields
  logic [TAG_W-1:0] req_tag, fill_tag, sb_tag;
  logic [IDX_W-1:0] req_idx, fill_idx, sb_idx;
  logic [WA_W-1:0]  req_waddr, fill_waddr;
  assign req_waddr  = req_addr[ADDR_W-1:BSEL_W];
  assign fill_waddr = fill_addr[ADDR_W-1:BSEL_W];
  assign req_tag    = req_waddr[WSEL_W+IDX_W +: TAG_W];
  assign req_idx    = req_waddr[WSEL_W +: IDX_W];
  assign fill_tag   = fill_waddr[WSEL_W+IDX_W +: TAG_W];
  assign fill_idx   = fill_waddr[WSEL_W +: IDX_W];

  logic lk_hit;
  dsb_tag_store #(.LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_idx (req_idx),
    .lk_tag (req_tag),
    .lk_hit (lk_hit),
    .wr_en  (fill_en),
    .wr_idx (fill_idx),
    .wr_tag (fill_tag)
  );

  // pending store entry
  logic              st_cycle, sb_vld, drop_en;
  logic [WA_W-1:0]   sb_waddr;
  logic [DATA_W-1:0] sb_data, arr_word, fwd_word;
  logic [BE_W-1:0]   sb_be;

  assign st_cycle = req_valid && (acc == ACC_STORE);
  assign sb_tag   = sb_waddr[WSEL_W+IDX_W +: TAG_W];
  assign sb_idx   = sb_waddr[WSEL_W +: IDX_W];
  assign drop_en  = fill_en && sb_vld && (sb_idx == fill_idx) && (sb_tag != fill_tag);

  dsb_store_buf #(.WA_W(WA_W), .DATA_W(DATA_W)) u_sbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_en    (st_cycle),
    .st_hit   (lk_hit),
    .st_waddr (req_waddr),
    .st_data  (req_wdata),
    .st_be    (req_be),
    .drop_en  (drop_en),
    .ld_waddr (req_waddr),
    .arr_word (arr_word),
    .fwd_word (fwd_word),
    .sb_vld   (sb_vld),
    .sb_waddr (sb_waddr),
    .sb_data  (sb_data),
    .sb_be    (sb_be)
  );

  // data array: commit of pending entry rides on every store cycle
  logic cm_en;
  assign cm_en = st_cycle && sb_vld;

  dsb_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_ent  (req_waddr[ENT_W-1:0]),
    .rd_data (arr_word),
    .cm_en   (cm_en),
    .cm_ent  (sb_waddr[ENT_W-1:0]),
    .cm_data (sb_data),
    .cm_be   (sb_be),
    .fl_en   (fill_en),
    .fl_ent  (fill_waddr[ENT_W-1:0]),
    .fl_data (fill_data)
  );

  // response stage
  logic              rsp_valid_d, rsp_hit_d, rsp_miss_d, rdata_en;
  logic              rsp_valid_q, rsp_hit_q, rsp_miss_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_hit_d   = req_valid && lk_hit;
    rsp_miss_d  = req_valid && !lk_hit;
    rdata_en    = req_valid && (acc == ACC_LOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_miss_q  <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_miss_q  <= rsp_miss_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rdata_en) rsp_rdata_q <= fwd_word;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_miss  = rsp_miss_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/dsb_cache_chk.sv
module dsb_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_store,
  input logic fill_en,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_miss,
  input logic sb_vld
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R3
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R3
  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss)); // R4
  AST_STORE_HIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |=> (rsp_hit |-> sb_vld)); // R5
  AST_STORE_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |=> (rsp_miss |-> !sb_vld)); // R7
  AST_LOAD_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |=> $stable(sb_vld)); // R8
  AST_FILL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && req_valid)); // R9
endmodule

bind dsb_cache dsb_cache_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_store (req_store),
  .fill_en   (fill_en),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .sb_vld    (sb_vld)
);

// File: tb/tb_dsb_cache.sv
module tb_dsb_cache;
  localparam int CLK_PERIOD = 10;
  localparam logic [21:0] TA = 22'h12345;
  localparam logic [21:0] TB = 22'h0ABCD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, fill_en;
  logic [31:0] req_addr, req_wdata, fill_addr, fill_data;
  logic [3:0]  req_be;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [31:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsb_cache dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_rdata(rsp_rdata)
  );

  typedef struct {
    logic        hit;
    logic        chk_data;
    logic [31:0] data;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;

  // reference model built from the requirements
  logic        m_vld [32];
  logic [21:0] m_tag [32];
  logic [31:0] m_dat [256];
  logic        m_pv;
  logic [29:0] m_pa;
  logic [31:0] m_pd;
  logic [3:0]  m_pbe;

  function automatic logic [31:0] mk(input logic [21:0] t, input logic [4:0] i,
                                     input logic [2:0] w);
    return {t, i, w, 2'b00};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] base,
                                        input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r = base;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0; fill_en = 1'b0;
    end
  endtask

  task automatic do_fill(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b1; fill_addr = a; fill_data = d;
    if (m_pv && m_pa[7:3] == a[9:5] && m_pa[29:8] != a[31:10]) m_pv = 1'b0;
    m_vld[a[9:5]] = 1'b1;
    m_tag[a[9:5]] = a[31:10];
    m_dat[a[9:2]] = d;
  endtask

  task automatic fill_line(input logic [21:0] t, input logic [4:0] i, input logic [31:0] seed);
    for (int w = 0; w < 8; w++) do_fill(mk(t, i, 3'(w)), seed + 32'(w) * 32'h0101_0101);
  endtask

  task automatic do_load(input logic [31:0] a, input string req);
    exp_t e;
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b1; req_store = 1'b0; req_addr = a;
    req_wdata = 32'h0; req_be = 4'h0;
    e.hit  = m_vld[a[9:5]] && (m_tag[a[9:5]] == a[31:10]);
    e.data = m_dat[a[9:2]];
    if (m_pv && m_pa == a[31:2]) e.data = merge(e.data, m_pd, m_pbe);
    e.chk_data = e.hit;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] be, input string req);
    exp_t e;
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b1; req_store = 1'b1; req_addr = a;
    req_wdata = d; req_be = be;
    if (m_pv) m_dat[m_pa[7:0]] = merge(m_dat[m_pa[7:0]], m_pd, m_pbe);
    e.hit = m_vld[a[9:5]] && (m_tag[a[9:5]] == a[31:10]);
    m_pv = e.hit;
    if (e.hit) begin m_pa = a[31:2]; m_pd = d; m_pbe = be; end
    e.chk_data = 1'b0; e.data = 32'h0; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R3: unexpected response, actual rsp_valid=1 expected 0");
      end else begin
        e = exp_q.pop_front();
        n_cmp++;
        if (rsp_hit !== e.hit || rsp_miss !== !e.hit ||
            (e.chk_data && rsp_rdata !== e.data)) begin
          n_bad++;
          $display("FAIL %s: actual hit=%b miss=%b data=%h expected hit=%b miss=%b data=%h",
                   e.req, rsp_hit, rsp_miss, rsp_rdata, e.hit, !e.hit, e.data);
        end
      end
    end
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; end
    for (int i = 0; i < 256; i++) m_dat[i] = 'x;
    m_pv = 1'b0; m_pa = '0; m_pd = '0; m_pbe = '0;
    req_valid = 0; req_store = 0; req_addr = 0; req_wdata = 0; req_be = 0;
    fill_en = 0; fill_addr = 0; fill_data = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: reset outputs actual v=%b h=%b m=%b expected 0 0 0",
               rsp_valid, rsp_hit, rsp_miss);
    end
    do_load(mk(TA, 5'd2, 3'd0), "R1");            // cold miss
    fill_line(TA, 5'd2, 32'h1000_0000);
    do_load(mk(TA, 5'd2, 3'd0), "R3");
    do_load(mk(TA, 5'd2, 3'd7), "R3");
    do_load(mk(TA, 5'd2, 3'd5) | 32'h3, "R2");   // byte select ignored
    do_load(mk(TB, 5'd2, 3'd0), "R4");            // tag conflict
    do_load(mk(TA, 5'd3, 3'd0), "R2");            // other index, invalid
    do_store(mk(TA, 5'd2, 3'd1), 32'hAABB_CCDD, 4'b0011, "R5");
    do_load(mk(TA, 5'd2, 3'd1), "R8");            // forwarded merge
    do_load(mk(TA, 5'd2, 3'd2), "R8");            // unrelated word
    do_store(mk(TA, 5'd2, 3'd3), 32'h5566_7788, 4'b1111, "R6");
    do_load(mk(TA, 5'd2, 3'd1), "R10");           // committed word 1
    do_load(mk(TA, 5'd2, 3'd3), "R8");
    do_store(mk(TB, 5'd2, 3'd0), 32'hDEAD_BEEF, 4'hF, "R7");
    do_load(mk(TA, 5'd2, 3'd0), "R7");            // resident line intact
    do_load(mk(TA, 5'd2, 3'd3), "R6");            // committed by missing store
    do_load(mk(TB, 5'd2, 3'd0), "R7");
    // drop on conflicting fill
    do_store(mk(TA, 5'd2, 3'd4), 32'h0404_0404, 4'hF, "R5");
    do_store(mk(TA, 5'd2, 3'd5), 32'h0505_0505, 4'hF, "R5");
    do_fill(mk(TB, 5'd2, 3'd0), 32'hBBBB_0000);
    do_load(mk(TA, 5'd2, 3'd4), "R9");            // line replaced
    do_fill(mk(TA, 5'd2, 3'd0), 32'hAAAA_0000);
    do_load(mk(TA, 5'd2, 3'd4), "R6");
    do_load(mk(TA, 5'd2, 3'd5), "R9");            // dropped store lost
    // same-tag fill keeps pending entry
    do_store(mk(TA, 5'd2, 3'd6), 32'h0606_0606, 4'b0101, "R5");
    do_fill(mk(TA, 5'd2, 3'd7), 32'h7777_7777);
    do_load(mk(TA, 5'd2, 3'd6), "R9");
    // back-to-back stores to one word
    do_store(mk(TA, 5'd2, 3'd2), 32'h1111_1111, 4'b0001, "R10");
    do_store(mk(TA, 5'd2, 3'd2), 32'h2222_2222, 4'b1000, "R10");
    do_load(mk(TA, 5'd2, 3'd2), "R10");
    do_store(mk(TA, 5'd2, 3'd0), 32'h3333_3333, 4'b0000, "R10");
    do_load(mk(TA, 5'd2, 3'd2), "R10");
    do_load(mk(TA, 5'd2, 3'd0), "R10");
    // random mix
    fill_line(TA, 5'd3, 32'h3000_0000);
    fill_line(TB, 5'd7, 32'h7000_0000);
    for (int n = 0; n < 600; n++) begin
      automatic int op = $urandom_range(0, 19);
      automatic logic [21:0] t = $urandom_range(0, 1) ? TA : TB;
      automatic logic [4:0]  i = $urandom_range(0, 1) ? 5'd3 : 5'd7;
      automatic logic [2:0]  w = 3'($urandom_range(0, 7));
      if (op == 0) fill_line(t, i, $urandom);
      else if (op < 10) do_load(mk(t, i, w), "R8");
      else do_store(mk(t, i, w), $urandom, 4'($urandom_range(0, 15)), "R6");
    end
    idle(4);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R3: actual %0d responses missing expected 0", exp_q.size());
    end
    summary();
  end
endmodule